// File: doc/BRIEF.md
# Distance-2 Symbol LFSR Pattern Generator with Parity Guard

This block is a built-in self-test pattern source. Its state is a chain of `K+T` symbols, each `DELTA` bits wide, and the chain shifts one symbol per step. Symbols are elements of GF(2^DELTA). The last symbol is fed back into every stage through a constant field multiplier. The feedback polynomial is a primitive polynomial p(x) of degree `K` multiplied by (x^T + 1). Because of the (x^T + 1) factor, the XOR of all symbols never changes while the block runs. It follows that any two successive states either are identical or differ in at least two bits. The whole state drives the pattern output in parallel.

The same invariant lets the block test itself. When a seed is loaded, a small guard state machine stores the seed's row parities. Row j is bit j of every symbol. On every later cycle the guard recomputes the row parities of the live state. Any difference moves the guard into a sticky fault state, and that raises `err`. A flip of any single state bit changes exactly one row parity, so the guard catches every such upset.

A test-only injection input flips one chosen state bit so the guard can be exercised. The guard states are `GRD_IDLE`, `GRD_WATCH` and `GRD_TRIP`:
- `GRD_IDLE` is entered at reset and means no reference is held yet.
- A seed load moves the guard from `GRD_IDLE` or `GRD_TRIP` to `GRD_WATCH`. A load while in `GRD_WATCH` stays in `GRD_WATCH` and captures a new reference.
- A parity mismatch moves the guard from `GRD_WATCH` to `GRD_TRIP`.
- `GRD_TRIP` holds until the next load or reset.

Top module: `d2g_pattern_gen`

## Requirements
- R1: On a clock edge with `seed_load` high, the state becomes `seed` exactly. This takes priority over `en` and `inj_en` in that cycle.
- R2: On an edge with `en` high, `seed_load` low and `inj_en` low, the state advances one step. Symbol i occupies bits `[i*DELTA +: DELTA]`, and bit j of a symbol is the coefficient of a^j. Let fb be the last symbol and c_i the coefficients of p(x)·(x^T+1) over the field defined by `GF_POLY`. Then the new symbol 0 is c_0·fb, and the new symbol i is (old symbol i-1) + c_i·fb.
- R3: With `en`, `seed_load` and `inj_en` all low, `pattern` holds its value.
- R4: With the default parameters, seed 18'h00009 produces 18'h00048, 18'h00240, 18'h01200, 18'h09000 and then 18'h14192, in that order.
- R5: Two successive stepped patterns are either equal or differ in at least two bit positions. From the R4 seed, no pattern repeats its predecessor over at least 1000 steps.
- R6: While stepping without injection, the XOR of all symbols (the row parities) equals that of the loaded seed.
- R7: On an edge with `inj_en` high and `seed_load` low, bit `inj_sel` of the value written that edge is inverted. The written value is the stepped state when `en` is high and the held state when `en` is low.
- R8: `err` rises on the edge after the corrupted state is first presented. It stays high until reset or the next seed load, and a load clears it at the load edge.
- R9: `err` is low after reset and before any load, and it stays low over at least 1000 fault-free steps.
- R10: `T`=2 is supported: the chain has `K+2` symbols, and R1–R3 and R5–R9 hold with that setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the state and idles the guard |
| en | input | 1 | Advance one step this cycle |
| seed_load | input | 1 | Load `seed` and capture its row parities |
| seed | input | N | Seed value, N = (K+T)·DELTA |
| inj_en | input | 1 | Test-only: invert one state bit at this edge |
| inj_sel | input | clog2(N) | Index of the bit to invert |
| pattern | output | N | Current generator state |
| err | output | 1 | Sticky self-check fault flag |

## Verification
The bench builds two copies of the block. Both use DELTA=3, K=5 and the default primitive polynomial; one has T=1 (18 bits) and the other T=2 (21 bits). With symbols of only 3 bits, the bench can carry out the field multiply and the polynomial product p(x)·(x^T+1) as plain carry-less arithmetic. It can therefore predict every step of both chains. The small width also makes it practical to inject a fault into every one of the 18 and 21 state bit positions, and to run a swept set of seeds and a run of more than 1000 steps on both variants.

// File: rtl/d2g_pkg.sv
package d2g_pkg;
    typedef enum logic [1:0] {
        GRD_IDLE  = 2'd0,
        GRD_WATCH = 2'd1,
        GRD_TRIP  = 2'd2
    } grd_state_e;
endpackage

// File: rtl/d2g_gf_cmul.sv
// Multiply a GF(2^W) element by a constant; pure XOR network.
module d2g_gf_cmul #(
    parameter int           W    = 3,
    parameter logic [W:0]   POLY = 4'b1101,
    parameter logic [W-1:0] COEF = '0
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    always_comb begin
        logic [W-1:0] sh;
        y  = '0;
        sh = a;
        for (int b = 0; b < W; b++) begin
            if (COEF[b]) y = y ^ sh;
            sh = (sh << 1) ^ (sh[W-1] ? POLY[W-1:0] : '0);
        end
    end
endmodule

// File: rtl/d2g_row_par.sv
// XOR of all symbols: bit j is the parity of row j.
module d2g_row_par #(
    parameter int D = 3,
    parameter int M = 6
) (
    input  logic [D*M-1:0] v,
    output logic [D-1:0]   par
);
    always_comb begin
        par = '0;
        for (int i = 0; i < M; i++) par = par ^ v[i*D +: D];
    end
endmodule

// File: rtl/d2g_sym_chain.sv
// Symbol-wise shift chain with constant-multiplier feedback.
module d2g_sym_chain #(
    parameter int             D    = 3,
    parameter int             K    = 5,
    parameter int             T    = 1,
    parameter logic [D:0]     POLY = 4'b1101,
    parameter logic [K*D-1:0] PRIM = 15'b010_110_110_000_010,
    localparam int            M    = K + T,
    localparam int            N    = M * D,
    localparam int            SW   = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic [N-1:0]  seed,
    input  logic          inj_en,
    input  logic [SW-1:0] inj_sel,
    output logic [N-1:0]  st
);
    // coefficient i of p(x), monic at degree K
    function automatic logic [D-1:0] p_at(input int i);
        if (i == K)               return D'(1);
        else if (i >= 0 && i < K) return PRIM[i*D +: D];
        else                      return '0;
    endfunction

    // coefficient i of p(x)*(x^T + 1)
    function automatic logic [D-1:0] phi_at(input int i);
        return p_at(i) ^ p_at(i - T);
    endfunction

    logic [D-1:0] fb;
    logic [N-1:0] nxt;
    logic [N-1:0] flip;

    assign fb   = st[(M-1)*D +: D];
    assign flip = {{(N-1){1'b0}}, 1'b1} << inj_sel;

    for (genvar i = 0; i < M; i++) begin : g_stage
        localparam logic [D-1:0] CI = phi_at(i);
        logic [D-1:0] prod;
        d2g_gf_cmul #(.W(D), .POLY(POLY), .COEF(CI)) u_mul (
            .a(fb),
            .y(prod)
        );
        if (i == 0) begin : g_head
            assign nxt[D-1:0] = prod;
        end else begin : g_body
            assign nxt[i*D +: D] = st[(i-1)*D +: D] ^ prod;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      st <= '0;
        else if (load)   st <= seed;
        else             st <= (en ? nxt : st) ^ (inj_en ? flip : '0);
    end
endmodule

// File: rtl/d2g_guard.sv
// Concurrent row-parity guard state machine.
module d2g_guard
    import d2g_pkg::*;
#(
    parameter int D = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [D-1:0] seed_par,
    input  logic [D-1:0] live_par,
    output logic         err
);
    grd_state_e   state_q, state_d;
    logic [D-1:0] ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GRD_IDLE;
            ref_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load) ref_q <= seed_par;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GRD_IDLE:  if (load) state_d = GRD_WATCH;
            GRD_WATCH: begin
                if (load)                   state_d = GRD_WATCH;
                else if (live_par != ref_q) state_d = GRD_TRIP;
            end
            GRD_TRIP:  if (load) state_d = GRD_WATCH;
            default:   state_d = GRD_IDLE;
        endcase
    end

    always_comb begin
        err = (state_q == GRD_TRIP);
    end
endmodule

// File: rtl/d2g_pattern_gen.sv
module d2g_pattern_gen #(
    parameter int                 DELTA     = 3,
    parameter int                 K         = 5,
    parameter int                 T         = 1,
    parameter logic [DELTA:0]     GF_POLY   = 4'b1101,
    parameter logic [K*DELTA-1:0] PRIM_COEF = 15'b010_110_110_000_010,
    localparam int                M         = K + T,
    localparam int                N         = M * DELTA,
    localparam int                SELW      = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            seed_load,
    input  logic [N-1:0]    seed,
    input  logic            inj_en,
    input  logic [SELW-1:0] inj_sel,
    output logic [N-1:0]    pattern,
    output logic            err
);
    logic [N-1:0]     st;
    logic [DELTA-1:0] seed_par;
    logic [DELTA-1:0] live_par;

    d2g_sym_chain #(
        .D(DELTA), .K(K), .T(T), .POLY(GF_POLY), .PRIM(PRIM_COEF)
    ) u_chain (
        .clk(clk), .rst_n(rst_n), .en(en), .load(seed_load), .seed(seed),
        .inj_en(inj_en), .inj_sel(inj_sel), .st(st)
    );

    d2g_row_par #(.D(DELTA), .M(M)) u_seed_par (.v(seed), .par(seed_par));
    d2g_row_par #(.D(DELTA), .M(M)) u_live_par (.v(st),   .par(live_par));

    d2g_guard #(.D(DELTA)) u_guard (
        .clk(clk), .rst_n(rst_n), .load(seed_load),
        .seed_par(seed_par), .live_par(live_par), .err(err)
    );

    assign pattern = st;
endmodule

// File: rtl/d2g_pattern_gen_sva.sv
module d2g_pattern_gen_sva #(
    parameter int DELTA = 3,
    parameter int K     = 5,
    parameter int T     = 1,
    localparam int M    = K + T,
    localparam int N    = M * DELTA,
    localparam int SELW = $clog2(N)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            seed_load,
    input logic [N-1:0]    seed,
    input logic            inj_en,
    input logic [SELW-1:0] inj_sel,
    input logic [N-1:0]    pattern,
    input logic            err
);
    logic [DELTA-1:0] obs_par;
    always_comb begin
        obs_par = '0;
        for (int i = 0; i < M; i++) obs_par = obs_par ^ pattern[i*DELTA +: DELTA];
    end

    a_r1_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> pattern == $past(seed));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !seed_load && !inj_en) |=> $stable(pattern));

    a_r5_min_dist: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !seed_load && !inj_en) |=>
            (pattern == $past(pattern)) || ($countones(pattern ^ $past(pattern)) >= 2));

    a_r6_row_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !seed_load && !inj_en) |=> obs_par == $past(obs_par));

    a_r7_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_en && !seed_load && !en && (32'(inj_sel) < N)) |=>
            $countones(pattern ^ $past(pattern)) == 1);

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !seed_load) |=> err);

    a_r8_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> !err);
endmodule

bind d2g_pattern_gen d2g_pattern_gen_sva #(.DELTA(DELTA), .K(K), .T(T)) u_sva (.*);

// File: tb/d2g_pattern_gen_bench.sv
module d2g_pattern_gen_bench;
    localparam int          DW    = 3;
    localparam int          KK    = 5;
    localparam logic [3:0]  GPOLY = 4'b1101;
    localparam logic [14:0] PR    = 15'b010_110_110_000_010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        en0 = 0, ld0 = 0, ij0 = 0;
    logic [17:0] sd0 = '0;
    logic [4:0]  is0 = '0;
    logic [17:0] pt0;
    logic        er0;
    logic        en1 = 0, ld1 = 0, ij1 = 0;
    logic [20:0] sd1 = '0;
    logic [4:0]  is1 = '0;
    logic [20:0] pt1;
    logic        er1;

    d2g_pattern_gen #(.DELTA(3), .K(5), .T(1)) u_d2g_pattern_gen (
        .clk(clk), .rst_n(rst_n), .en(en0), .seed_load(ld0), .seed(sd0),
        .inj_en(ij0), .inj_sel(is0), .pattern(pt0), .err(er0));

    d2g_pattern_gen #(.DELTA(3), .K(5), .T(2)) u_d2g_pattern_gen_t2 (
        .clk(clk), .rst_n(rst_n), .en(en1), .seed_load(ld1), .seed(sd1),
        .inj_en(ij1), .inj_sel(is1), .pattern(pt1), .err(er1));

    int  n_run = 0, n_fail = 0;
    bit  done = 0;

    // carry-less product then reduction by GPOLY
    function automatic logic [2:0] gmul(input logic [2:0] a, input logic [2:0] b);
        logic [4:0] p = '0;
        for (int i = 0; i < 3; i++) if (b[i]) p = p ^ (5'(a) << i);
        for (int k = 4; k >= 3; k--) if (p[k]) p = p ^ (5'(GPOLY) << (k - 3));
        return p[2:0];
    endfunction

    function automatic logic [2:0] pco(input int i);
        if (i == KK) return 3'd1;
        if (i < 0 || i > KK) return 3'd0;
        return PR[i*3 +: 3];
    endfunction

    // coefficient i of p(x)*(x^t + 1)
    function automatic logic [2:0] fco(input int i, input int t);
        logic [2:0] c = '0;
        for (int a = 0; a <= KK; a++)
            for (int e = 0; e <= t; e += t)
                if (a + e == i) c = c ^ pco(a);
        return c;
    endfunction

    function automatic logic [20:0] mstep(input logic [20:0] s, input int t);
        int m = KK + t;
        logic [2:0] fb = s[(m-1)*3 +: 3];
        logic [20:0] r = '0;
        for (int i = 0; i < m; i++) begin
            logic [2:0] prv = (i == 0) ? 3'd0 : s[(i-1)*3 +: 3];
            r[i*3 +: 3] = prv ^ gmul(fco(i, t), fb);
        end
        return r;
    endfunction

    function automatic logic [2:0] rpar(input logic [20:0] s);
        logic [2:0] p = '0;
        for (int i = 0; i < 7; i++) p = p ^ s[i*3 +: 3];
        return p;
    endfunction

    function automatic logic [20:0] pat(input int w);
        return (w == 0) ? {3'b0, pt0} : pt1;
    endfunction
    function automatic logic erf(input int w);
        return (w == 0) ? er0 : er1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [20:0] act, input logic [20:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one instance for one edge, then wait to the next negedge
    task automatic drive(input int w, input logic e, input logic l, input logic [20:0] s,
                         input logic ij, input logic [4:0] sel);
        if (w == 0) begin en0 = e; ld0 = l; sd0 = s[17:0]; ij0 = ij; is0 = sel; end
        else        begin en1 = e; ld1 = l; sd1 = s;       ij1 = ij; is1 = sel; end
        @(negedge clk);
    endtask

    task automatic idle(input int w);
        if (w == 0) begin en0 = 0; ld0 = 0; ij0 = 0; end
        else        begin en1 = 0; ld1 = 0; ij1 = 0; end
    endtask

    // load then step n times with full model checks
    task automatic run_seed(input int w, input logic [20:0] s, input int n, input bit strict);
        int t = w + 1;
        logic [20:0] cur, prv;
        drive(w, 1, 1, s, 1, 5'd0);
        check(pat(w) == s, "R1", pat(w), s);
        cur = s;
        for (int k = 0; k < n; k++) begin
            drive(w, 1, 0, '0, 0, 5'd0);
            prv = cur;
            cur = mstep(prv, t);
            check(pat(w) == cur, (w == 0) ? "R2" : "R10", pat(w), cur);
            check(pat(w) == prv || $countones(pat(w) ^ prv) >= 2, "R5", pat(w), prv);
            if (strict) check(pat(w) != prv, "R5", pat(w), prv);
            check(rpar(pat(w)) == rpar(s), "R6", 21'(rpar(pat(w))), 21'(rpar(s)));
            check(erf(w) == 1'b0, "R9", 21'(erf(w)), 21'd0);
        end
        idle(w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [20:0] cur, exp_v;
        logic [31:0] lcg = 32'h1234_5678;
        logic [17:0] refseq [6];
        refseq[0] = 18'h00009; refseq[1] = 18'h00048; refseq[2] = 18'h00240;
        refseq[3] = 18'h01200; refseq[4] = 18'h09000; refseq[5] = 18'h14192;

        repeat (3) @(negedge clk);
        // R9: reset state and idle guard
        check(pt0 == '0, "R9 reset pattern", 21'(pt0), 0);
        check(er0 == 0 && er1 == 0, "R9 reset err", 21'({er0, er1}), 0);
        rst_n = 1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) drive(0, 1, 0, '0, 0, 5'd0);
        check(er0 == 0 && pt0 == '0, "R9 idle no load", 21'({er0, pt0}), 0);
        idle(0);

        // R4: reference sequence
        drive(0, 1, 1, 21'(refseq[0]), 0, 5'd0);
        check(pt0 == refseq[0], "R4 seed", 21'(pt0), 21'(refseq[0]));
        for (int k = 1; k < 6; k++) begin
            drive(0, 1, 0, '0, 0, 5'd0);
            check(pt0 == refseq[k], "R4 sequence", 21'(pt0), 21'(refseq[k]));
        end

        // R3: hold
        cur = 21'(pt0);
        for (int k = 0; k < 3; k++) begin
            drive(0, 0, 0, '0, 0, 5'd0);
            check(21'(pt0) == cur, "R3 hold", 21'(pt0), cur);
        end

        // R5/R6/R9: long fault-free runs from the reference seed
        run_seed(0, 21'h00009, 1200, 1);
        run_seed(1, 21'h00009, 1200, 1);

        // R2/R10 sweep of seeds on both variants
        for (int w = 0; w < 2; w++)
            for (int j = 0; j < 40; j++) begin
                lcg = lcg * 32'd1103515245 + 32'd12345;
                run_seed(w, (w == 0) ? 21'(lcg[27:10]) : lcg[30:10], 30, 0);
            end

        // R1: load beats step and injection
        drive(0, 1, 1, 21'h2AAAA, 1, 5'd3);
        check(pt0 == 18'h2AAAA, "R1 priority", 21'(pt0), 21'h2AAAA);
        drive(0, 1, 0, '0, 0, 5'd0);
        check(er0 == 0, "R1 no injection during load", 21'(er0), 0);

        // R7/R8: inject every bit on both variants
        for (int w = 0; w < 2; w++) begin
            int nb = (w == 0) ? 18 : 21;
            for (int b = 0; b < nb; b++) begin
                drive(w, 1, 1, 21'h00009, 0, 5'd0);
                drive(w, 1, 0, '0, 0, 5'd0);
                cur = mstep(21'h00009, w + 1);
                drive(w, 1, 0, '0, 1, 5'(b));
                exp_v = mstep(cur, w + 1) ^ (21'd1 << b);
                check(pat(w) == exp_v, "R7 stepped flip", pat(w), exp_v);
                check(erf(w) == 0, "R8 not yet", 21'(erf(w)), 0);
                drive(w, 1, 0, '0, 0, 5'd0);
                exp_v = mstep(exp_v, w + 1);
                check(pat(w) == exp_v, "R7 continues", pat(w), exp_v);
                check(erf(w) == 1, "R8 raise", 21'(erf(w)), 1);
                drive(w, 1, 0, '0, 0, 5'd0);
                drive(w, 0, 0, '0, 0, 5'd0);
                check(erf(w) == 1, "R8 sticky", 21'(erf(w)), 1);
                drive(w, 0, 1, 21'h00009, 0, 5'd0);
                check(erf(w) == 0, "R8 cleared by load", 21'(erf(w)), 0);
            end
            idle(w);
        end

        // R7: injection while holding
        drive(0, 1, 1, 21'h00048, 0, 5'd0);
        drive(0, 0, 0, '0, 1, 5'd17);
        check(pt0 == 18'h20048, "R7 held flip", 21'(pt0), 21'h20048);
        drive(0, 0, 0, '0, 0, 5'd0);
        check(er0 == 1, "R8 held flip raises", 21'(er0), 1);
        idle(0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule